// File: doc/BRIEF.md
# Gen2 Stuck-Link Recovery Watchdog

This block supervises a PCIe link while it is brought up and repairs a lane receiver that has locked up while moving to the second-generation signalling rate. A start pulse begins a run of link checks spaced at a fixed interval. At each check the block first looks at the link-up indication. If the link is not up yet, it reads the lane receiver status word through a control-register bus master. If the LTSSM reports the Recovery.RcvrLock state while the receiver reports no valid data, the rate change is taken as stuck.

To repair a stuck rate change, the block writes the lane receiver override word so that the receiver PLL enable and the data enable are forced low. It holds that override for a fixed time and then writes the override word back to zero. When the link comes up, the run ends with a success flag. When the check budget is used up, the run ends with a fail flag that stays set until the next start or reset. The block reaches the PHY only through single request/done transactions on the bus master, so it can sit next to any controller that already owns that bus.

Top module: `gen2_recovery_watchdog`

## Requirements
- R1: A start pulse is honoured only while no run is active. It clears `link_ok` and `link_fail` on the next clock edge. The first check takes place INTERVAL_CYCLES+1 cycles after the cycle in which start is high, and each later check follows the previous one's completion after the same interval.
- R2: If `link_up` is high at a check, `link_ok` is set, the run ends, and no bus request is made for that check or afterwards.
- R3: If `link_up` is low at a check, the block issues a read (`req_write`=0) of address 0x100D, the lane receiver status word. Bit 0 of that word is receive-valid; bits 1 and 2 report PLL state and loss of signal.
- R4: A check counts as stuck when `ltssm_state` equals 0x0D and bit 0 of the returned status is 0, whatever the other status bits hold. A stuck check is followed at once by a write of 0x0028 to address 0x1005. That value sets override bits 3 and 5 and holds enable bits 2 and 4 at 0.
- R5: After the forcing write completes, no request is made for HOLD_CYCLES cycles. The release write of 0x0000 to address 0x1005 then starts HOLD_CYCLES+1 cycles after the cycle in which the forcing write's done was high.
- R6: A check that is not stuck, because the LTSSM state is not 0x0D or receive-valid is 1, makes no write.
- R7: A done with `rsp_error` high on the status read, or on the forcing write, ends that check with no further request. The check still counts toward the limit.
- R8: After MAX_CHECKS checks without link-up, `link_fail` is set. It stays set, and no request is made, until a new start or reset.
- R9: Once `req_valid` is raised, it and the request fields stay stable until the cycle in which `rsp_done` is high.
- R10: `link_ok` and `link_fail` are never high together.
- R11: While reset is asserted, and directly after it, `link_ok`, `link_fail` and `req_valid` are 0. A reset in the middle of a run abandons that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a supervision run (pulse) |
| ltssm_state | input | 6 | Current LTSSM state code |
| link_up | input | 1 | Link-up indication from the controller debug word |
| req_valid | output | 1 | Bus-master request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Control-register address |
| req_wdata | output | 16 | Write data |
| rsp_done | input | 1 | Single-cycle completion of the pending request |
| rsp_error | input | 1 | Completion carried an error (valid with rsp_done) |
| rsp_rdata | input | 16 | Read data (valid with rsp_done) |
| link_ok | output | 1 | Run ended with link up |
| link_fail | output | 1 | Run ended with the check budget used up |

## Verification
The bench builds the block with INTERVAL_CYCLES=8, HOLD_CYCLES=5 and MAX_CHECKS=4. With these values, a run that exhausts its budget takes only about a hundred cycles, and the interval and hold spacing can be counted exactly at the ports. A bench bus responder answers after two cycles. It can inject errors on every request or on writes only, which exercises the skip path on reads and on the forcing write. The stall test uses status words with the PLL and loss-of-signal bits set, to show that only receive-valid matters. It also uses LTSSM codes next to 0x0D, to show that the state compare is exact.

// File: rtl/gw_pkg.sv
package gw_pkg;

  localparam int unsigned BUS_AW = 16;
  localparam int unsigned BUS_DW = 16;

  localparam logic [BUS_AW-1:0] RX_STATUS_ADDR = 16'h100D;
  localparam logic [BUS_AW-1:0] RX_OVR_ADDR    = 16'h1005;
  localparam logic [BUS_DW-1:0] OVR_FORCE_OFF  = 16'h0028;
  localparam logic [BUS_DW-1:0] OVR_RELEASE    = 16'h0000;
  localparam logic [5:0]        LTSSM_RCVRLOCK = 6'h0D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_FORCE,
    ST_HOLD,
    ST_RELEASE,
    ST_NEXT
  } gw_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // stuck rate change: receiver-lock state with no valid receive data
  function automatic logic is_stuck(input logic [5:0] ltssm, input logic rx_valid);
    return (ltssm == LTSSM_RCVRLOCK) && !rx_valid;
  endfunction

endpackage

// File: rtl/gw_timer.sv
module gw_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/gw_check_counter.sv
module gw_check_counter #(
  parameter int unsigned MAX_CHECKS = 200,
  localparam int unsigned CW = $clog2(MAX_CHECKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (inc)        cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == CW'(MAX_CHECKS - 1));
endmodule

// File: rtl/gw_fsm.sv
module gw_fsm
  import gw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        ltssm_state,
  input  logic              link_up,
  input  logic              rsp_done,
  input  logic              rsp_error,
  input  logic              rx_valid,
  input  logic              tmr_zero,
  input  logic              last_check,
  output logic              tmr_load,
  output logic              tmr_hold_sel,
  output logic              cnt_clear,
  output logic              cnt_inc,
  output logic              req_valid,
  output logic              req_write,
  output logic [BUS_AW-1:0] req_addr,
  output logic [BUS_DW-1:0] req_wdata,
  output logic              link_ok,
  output logic              link_fail,
  output logic              stall_hit,
  output logic              hold_active,
  output logic              idle
);
  gw_state_t state_q, state_d;
  logic set_ok, set_fail, clr_flags;

  always_comb begin
    state_d      = state_q;
    tmr_load     = 1'b0;
    tmr_hold_sel = 1'b0;
    cnt_clear    = 1'b0;
    cnt_inc      = 1'b0;
    req_valid    = 1'b0;
    req_write    = 1'b0;
    req_addr     = RX_STATUS_ADDR;
    req_wdata    = OVR_RELEASE;
    set_ok       = 1'b0;
    set_fail     = 1'b0;
    clr_flags    = 1'b0;
    stall_hit    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        clr_flags = 1'b1;
        cnt_clear = 1'b1;
        tmr_load  = 1'b1;
        state_d   = ST_WAIT;
      end
      ST_WAIT: if (tmr_zero) begin
        if (link_up) begin
          set_ok  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        req_valid = 1'b1;
        if (rsp_done) begin
          if (!rsp_error && is_stuck(ltssm_state, rx_valid)) begin
            stall_hit = 1'b1;
            state_d   = ST_FORCE;
          end else begin
            state_d   = ST_NEXT;
          end
        end
      end
      ST_FORCE: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = RX_OVR_ADDR;
        req_wdata = OVR_FORCE_OFF;
        if (rsp_done) begin
          if (rsp_error) state_d = ST_NEXT;
          else begin
            tmr_load     = 1'b1;
            tmr_hold_sel = 1'b1;
            state_d      = ST_HOLD;
          end
        end
      end
      ST_HOLD: if (tmr_zero) state_d = ST_RELEASE;
      ST_RELEASE: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = RX_OVR_ADDR;
        req_wdata = OVR_RELEASE;
        if (rsp_done) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        cnt_inc = 1'b1;
        if (last_check) begin
          set_fail = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      link_ok   <= 1'b0;
      link_fail <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_flags) begin
        link_ok   <= 1'b0;
        link_fail <= 1'b0;
      end
      if (set_ok)   link_ok   <= 1'b1;
      if (set_fail) link_fail <= 1'b1;
    end
  end

  assign hold_active = (state_q == ST_HOLD);
  assign idle        = (state_q == ST_IDLE);
endmodule

// File: rtl/gen2_recovery_watchdog.sv
module gen2_recovery_watchdog
  import gw_pkg::*;
#(
  parameter int unsigned INTERVAL_CYCLES = 200000,
  parameter int unsigned HOLD_CYCLES     = 200000,
  parameter int unsigned MAX_CHECKS      = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  ltssm_state,
  input  logic        link_up,
  output logic        req_valid,
  output logic        req_write,
  output logic [15:0] req_addr,
  output logic [15:0] req_wdata,
  input  logic        rsp_done,
  input  logic        rsp_error,
  input  logic [15:0] rsp_rdata,
  output logic        link_ok,
  output logic        link_fail
);
  localparam int unsigned TW = $clog2(max_u(INTERVAL_CYCLES, HOLD_CYCLES) + 1);
  localparam logic [TW-1:0] INTERVAL_LOAD = TW'(INTERVAL_CYCLES - 1);
  localparam logic [TW-1:0] HOLD_LOAD     = TW'(HOLD_CYCLES - 1);

  // events brought out for the bound checker
  logic stall_hit, hold_active, idle;
  logic tmr_load, tmr_hold_sel, tmr_zero;
  logic cnt_clear, cnt_inc, last_check;
  logic [TW-1:0] tmr_val;
  logic unused_status;

  // only receive-valid is decoded from the status word
  assign unused_status = ^rsp_rdata[15:1];
  assign tmr_val = tmr_hold_sel ? HOLD_LOAD : INTERVAL_LOAD;

  gw_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  gw_check_counter #(.MAX_CHECKS(MAX_CHECKS)) u_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .inc   (cnt_inc),
    .last  (last_check)
  );

  gw_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ltssm_state  (ltssm_state),
    .link_up      (link_up),
    .rsp_done     (rsp_done),
    .rsp_error    (rsp_error),
    .rx_valid     (rsp_rdata[0]),
    .tmr_zero     (tmr_zero),
    .last_check   (last_check),
    .tmr_load     (tmr_load),
    .tmr_hold_sel (tmr_hold_sel),
    .cnt_clear    (cnt_clear),
    .cnt_inc      (cnt_inc),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .link_ok      (link_ok),
    .link_fail    (link_fail),
    .stall_hit    (stall_hit),
    .hold_active  (hold_active),
    .idle         (idle)
  );
endmodule

// File: rtl/gw_recovery_checks.sv
module gw_recovery_checks
  import gw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        req_valid,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic [15:0] req_wdata,
  input logic        rsp_done,
  input logic        link_ok,
  input logic        link_fail,
  input logic        stall_hit,
  input logic        hold_active,
  input logic        idle
);
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && idle |=> !link_ok && !link_fail);

  assert_read_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |-> req_addr == RX_STATUS_ADDR);

  assert_force_follows_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hit |=> req_valid && req_write && req_addr == RX_OVR_ADDR && req_wdata == OVR_FORCE_OFF);

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !req_valid);

  assert_write_values_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_addr == RX_OVR_ADDR &&
      (req_wdata == OVR_FORCE_OFF || req_wdata == OVR_RELEASE));

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail && !start |=> link_fail);

  assert_fail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> !req_valid);

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_done |=> req_valid && $stable(req_write) &&
      $stable(req_addr) && $stable(req_wdata));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_ok && link_fail));
endmodule

bind gen2_recovery_watchdog gw_recovery_checks u_checks_bind (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_done    (rsp_done),
  .link_ok     (link_ok),
  .link_fail   (link_fail),
  .stall_hit   (stall_hit),
  .hold_active (hold_active),
  .idle        (idle)
);

// File: tb/gen2_recovery_watchdog_bench.sv
module gen2_recovery_watchdog_bench;
  localparam int I_CYC = 8;
  localparam int H_CYC = 5;
  localparam int M_CHK = 4;
  localparam int NONE  = 15;

  typedef struct packed {
    logic [3:0]  up_after;   // link_up rises after this many status reads (15 = never)
    logic [5:0]  ltssm;
    logic [15:0] status;
    logic [1:0]  emode;      // 0 none, 1 every request, 2 writes only
    logic        exp_ok;
    logic [3:0]  exp_reads;
    logic [3:0]  exp_writes;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{4'd0,  6'h11, 16'h0001, 2'd0, 1'b1, 4'd0, 4'd0},  // R2 up at first check
    '{4'd3,  6'h0D, 16'h0001, 2'd0, 1'b1, 4'd3, 4'd0},  // R6 valid set
    '{4'd2,  6'h0D, 16'h0000, 2'd0, 1'b1, 4'd2, 4'd4},  // R4 R5 recover twice
    '{4'd15, 6'h0D, 16'h0000, 2'd0, 1'b0, 4'd4, 4'd8},  // R8 exhaust with stalls
    '{4'd15, 6'h0C, 16'h0000, 2'd0, 1'b0, 4'd4, 4'd0},  // R6 adjacent state
    '{4'd15, 6'h0D, 16'h0000, 2'd1, 1'b0, 4'd4, 4'd0},  // R7 read errors
    '{4'd15, 6'h0D, 16'h0006, 2'd0, 1'b0, 4'd4, 4'd8},  // R4 other status bits ignored
    '{4'd15, 6'h0D, 16'h0000, 2'd2, 1'b0, 4'd4, 4'd4}   // R7 forcing write errors
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, link_up = 1'b0;
  logic [5:0] ltssm_state = 6'h00;
  logic req_valid, req_write, link_ok, link_fail;
  logic [15:0] req_addr, req_wdata;
  logic rsp_done = 1'b0, rsp_error = 1'b0;
  logic [15:0] rsp_rdata = 16'h0;

  int total = 0, bad = 0;
  int cyc = 0, reads = 0, writes = 0, addr_bad = 0, accepts = 0;
  int up_after = NONE, emode = 0;
  logic [15:0] status_word = 16'h0;
  int t_start = 0, first_gap = -1, t_force = -1, hold_gap = -1;
  bit busy = 0, prev_done = 0;
  int lat = 0;

  gen2_recovery_watchdog #(
    .INTERVAL_CYCLES(I_CYC), .HOLD_CYCLES(H_CYC), .MAX_CHECKS(M_CHK)
  ) u_gen2_recovery_watchdog (
    .clk(clk), .rst_n(rst_n), .start(start), .ltssm_state(ltssm_state),
    .link_up(link_up), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .link_ok(link_ok),
    .link_fail(link_fail)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus responder: two-cycle latency, single-cycle done
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      prev_done = rsp_done;
      rsp_done  = 1'b0;
      rsp_error = 1'b0;
      if (busy) begin
        lat--;
        if (lat == 0) begin
          busy = 0;
          rsp_done  = 1'b1;
          rsp_error = (emode == 1) || (emode == 2 && req_write);
          rsp_rdata = status_word;
          if (!req_write) begin
            reads++;
            if (req_addr != 16'h100D) addr_bad++;
          end else begin
            writes++;
            if (req_addr != 16'h1005 || (req_wdata != 16'h0028 && req_wdata != 16'h0000))
              addr_bad++;
            if (req_wdata == 16'h0028 && !rsp_error) t_force = cyc;
          end
        end
      end else if (req_valid && !prev_done) begin
        busy = 1;
        lat  = 2;
        accepts++;
        if (!req_write && first_gap < 0) first_gap = cyc - t_start;
        if (req_write && req_wdata == 16'h0000 && hold_gap < 0 && t_force >= 0)
          hold_gap = cyc - t_force;
      end
      link_up = (up_after != NONE) && (reads >= up_after);
    end
  end

  // watchdog
  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); #1;
    start = 1'b1;
    t_start = cyc;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 600; k++) begin
      if (link_ok || link_fail) break;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 link_ok in reset", int'(link_ok), 0);
    check("R11 link_fail in reset", int'(link_fail), 0);
    check("R11 req_valid in reset", int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 req_valid after reset", int'(req_valid), 0);

    for (int v = 0; v < 8; v++) begin
      up_after    = int'(VECS[v].up_after);
      ltssm_state = VECS[v].ltssm;
      status_word = VECS[v].status;
      emode       = int'(VECS[v].emode);
      reads = 0; writes = 0; addr_bad = 0;
      first_gap = -1; t_force = -1; hold_gap = -1;
      @(negedge clk); #1;
      pulse_start();
      wait_end();
      check($sformatf("R2 R8 vec%0d link_ok", v), int'(link_ok), int'(VECS[v].exp_ok));
      check($sformatf("R8 vec%0d link_fail", v), int'(link_fail), int'(!VECS[v].exp_ok));
      check($sformatf("R3 R7 vec%0d reads", v), reads, int'(VECS[v].exp_reads));
      check($sformatf("R4 R6 R7 vec%0d writes", v), writes, int'(VECS[v].exp_writes));
      check($sformatf("R3 R4 vec%0d address/data", v), addr_bad, 0);
      if (v == 3) begin
        check("R1 first check spacing", first_gap, I_CYC + 1);
        check("R5 override hold spacing", hold_gap, H_CYC + 1);
        accepts = 0;
        repeat (30) @(negedge clk);
        #1;
        check("R8 fail held", int'(link_fail), 1);
        check("R8 no request after fail", accepts, 0);
        pulse_start();
        check("R1 start clears fail", int'(link_fail), 0);
        wait_end();
        check("R8 second run fails", int'(link_fail), 1);
      end
    end

    // reset in the middle of an override hold
    up_after = NONE; ltssm_state = 6'h0D; status_word = 16'h0; emode = 0;
    t_force = -1;
    pulse_start();
    for (int k = 0; k < 200; k++) begin
      if (t_force >= 0) break;
      @(negedge clk); #1;
    end
    rst_n = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b1;
    accepts = 0;
    repeat (20) @(negedge clk);
    #1;
    check("R11 req after mid-run reset", accepts, 0);
    check("R11 flags after mid-run reset", int'(link_ok) + int'(link_fail), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule